// File: doc/BRIEF.md
# Dual-Half LCD Pixel Serializer

This block turns the display bytes fetched for the two halves of a split LCD panel into the bit streams that the column (segment) drivers shift in. Each character period it is handed one byte for the upper half and one for the lower half. From each byte it keeps only the leading pitch bits, the first bit shown being bit 7. It packs those bits without gaps into groups of one, two or four bits, depending on the output mode. It presents each group on the data pins together with a shift clock for the driver.

The block clock runs at twice the dot rate. A shift clock period is as many dots as there are bits in a group, so the shift clock runs at the dot rate, half of it or a quarter of it. Data changes while the shift clock is low, at its falling edge, and holds still while it is high, so the driver can sample on the rising edge. The first group appears one shift period after the first accepted byte of a line. While the line-blanking flag is high, new bytes are refused. The queued bits drain, the last group is padded with zeros, and then the shift clock stops until the next line starts. Upstream must present bytes every pitch dots (2 × pitch clocks) without gaps through a line.

Top module: `lcd_dual_serializer`

## Requirements
- R1: After synchronous reset, `ud`, `ld` and `clp` are all zero.
- R2: In serial mode (`out_mode` = 00) each group is one bit: the upper-half bit is on `ud[0]` and the lower-half bit on `ud[1]`. `ud[3:2]` are zero.
- R3: In pair mode (`out_mode` = 01) each group is two bits. The earlier upper bit is on `ud[0]` and the later on `ud[1]`; the earlier lower bit is on `ud[2]` and the later on `ud[3]`.
- R4: In nibble mode (`out_mode` = 10 or 11) each group is four bits. The upper half uses `ud[3:0]` and the lower half `ld[3:0]`, with the earliest bit on pin 3 and the latest on pin 0.
- R5: Of each accepted byte only bits 7 down to 8−P are shown, where P is the effective pitch. They go out most significant first and are packed across characters with no gap. A line of N characters yields ceil(N·P / W) shift clocks, where W is the group width; bits beyond the last one shown are zero.
- R6: The shift clock has a period of 2W block clocks (W dots) and is high for W clocks of each period.
- R7: The data pins change only while `clp` is low; they are stable through every high phase.
- R8: While `line_blank` is high, `chr_load` is ignored. Once the queued bits have drained, no further shift clock is issued and the data pins stay zero.
- R9: While `disp_on` is low, the data pins and `clp` are zero from the next cycle on, loads are ignored, and queued bits are discarded.
- R10: Outside nibble mode `ld` stays zero.
- R11: A `pitch` value below 4 acts as 4 and a value above 8 acts as 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, twice the dot rate |
| rst | input | 1 | Synchronous active-high reset |
| disp_on | input | 1 | Display enable; low blanks all outputs |
| out_mode | input | 2 | 00 serial, 01 pair, 1x nibble |
| pitch | input | 4 | Bits shown per byte (4..8, clamped) |
| chr_load | input | 1 | One-cycle strobe: bytes valid this cycle |
| line_blank | input | 1 | High during the per-line transfer gap |
| up_byte | input | 8 | Byte for the upper half |
| lo_byte | input | 8 | Byte for the lower half |
| ud | output | 4 | Upper data pins (also lower data outside nibble mode) |
| ld | output | 4 | Lower data pins in nibble mode |
| clp | output | 1 | Shift clock to the drivers |

## Verification
On every cycle the assertions check the shift clock's high time against the group width, the stability of the data while the clock is high, the forced-zero outputs while the display is off, and the idle lower bus outside nibble mode. The bench sweeps every mode against every pitch, including clamped values, with random bytes. Only these scenarios can show the bit order on each pin, the gapless packing across characters, the zero padding and count of the final group, and that loads during blanking or display-off leave no trace.

// File: rtl/lcds_pkg.sv
package lcds_pkg;

    localparam int BYTE_W = 8;
    localparam int NIB_W  = 4;
    localparam int QUE_W  = 2 * BYTE_W;
    localparam int CNT_W  = $clog2(QUE_W + 1);
    localparam int PC_W   = 3;
    localparam int PIT_W  = 4;
    localparam int LAN_W  = 3;

    typedef enum logic [1:0] {
        OM_SERIAL  = 2'b00,
        OM_PAIR    = 2'b01,
        OM_NIBBLE  = 2'b10,
        OM_NIBBLE2 = 2'b11
    } outmode_t;

    typedef struct packed {
        logic [NIB_W-1:0] up;
        logic [NIB_W-1:0] lo;
    } grp_pair_t;

    function automatic logic [LAN_W-1:0] lanes_of(input logic [1:0] m);
        case (m)
            2'b00:   lanes_of = 3'd1;
            2'b01:   lanes_of = 3'd2;
            default: lanes_of = 3'd4;
        endcase
    endfunction

    function automatic logic [PIT_W-1:0] pitch_clamp(input logic [PIT_W-1:0] hp);
        if (hp < 4'd4)      pitch_clamp = 4'd4;
        else if (hp > 4'd8) pitch_clamp = 4'd8;
        else                pitch_clamp = hp;
    endfunction

endpackage

// File: rtl/lcds_bitq.sv
module lcds_bitq
    import lcds_pkg::*;
#(
    parameter int BW = BYTE_W,
    parameter int QW = QUE_W,
    parameter int CW = CNT_W,
    parameter int GW = NIB_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             load,
    input  logic [BW-1:0]    din,
    input  logic [PIT_W-1:0] pitch,
    input  logic [LAN_W-1:0] lanes,
    input  logic             pop,
    output logic [GW-1:0]    grp,
    output logic             nonempty
);

    logic [QW-1:0] q, q_app, ext;
    logic [CW-1:0] cnt, cnt_app, take;
    logic [BW-1:0] keep_mask, din_m;
    logic [GW-1:0] lane_mask;

    always_comb begin
        keep_mask = ~({BW{1'b1}} >> pitch);
        din_m     = din & keep_mask;
        ext       = {din_m, {(QW-BW){1'b0}}} >> cnt;
        q_app     = load ? (q | ext) : q;
        cnt_app   = cnt + (load ? CW'(pitch) : '0);
        take      = (cnt_app < CW'(lanes)) ? cnt_app : CW'(lanes);
        lane_mask = ~({GW{1'b1}} >> lanes);
        nonempty  = (cnt_app != '0);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            q   <= '0;
            cnt <= '0;
            grp <= '0;
        end else if (pop) begin
            q   <= q_app << lanes;
            cnt <= cnt_app - take;
            grp <= q_app[QW-1 -: GW] & lane_mask;
        end else begin
            q   <= q_app;
            cnt <= cnt_app;
        end
    end

endmodule

// File: rtl/lcds_pacer.sv
module lcds_pacer
    import lcds_pkg::*;
#(
    parameter int PW = PC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             kick,
    input  logic             have_bits,
    input  logic [LAN_W-1:0] lanes,
    output logic             pop,
    output logic             clp
);

    logic          running, running_n;
    logic          act, act_n;
    logic          clp_n;
    logic [PW-1:0] pc, pc_n, pc_last;

    always_comb begin
        pc_last   = PW'({lanes, 1'b0} - 4'd1);
        pop       = en && running && (pc == pc_last);
        running_n = running;
        act_n     = act;
        pc_n      = pc;
        if (!en) begin
            running_n = 1'b0;
            act_n     = 1'b0;
            pc_n      = '0;
        end else if (running) begin
            pc_n = pop ? '0 : pc + 1'b1;
            if (pop) begin
                act_n     = have_bits;
                running_n = have_bits;
            end
        end else if (kick) begin
            running_n = 1'b1;
            pc_n      = '0;
        end
        clp_n = act_n && (pc_n >= PW'(lanes));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            act     <= 1'b0;
            pc      <= '0;
            clp     <= 1'b0;
        end else begin
            running <= running_n;
            act     <= act_n;
            pc      <= pc_n;
            clp     <= clp_n;
        end
    end

endmodule

// File: rtl/lcds_pinmap.sv
module lcds_pinmap
    import lcds_pkg::*;
(
    input  logic [1:0]       mode,
    input  grp_pair_t        grp,
    output logic [NIB_W-1:0] ud,
    output logic [NIB_W-1:0] ld
);

    always_comb begin
        ud = '0;
        ld = '0;
        case (outmode_t'(mode))
            OM_SERIAL: begin
                ud[0] = grp.up[3];
                ud[1] = grp.lo[3];
            end
            OM_PAIR: begin
                ud[0] = grp.up[3];
                ud[1] = grp.up[2];
                ud[2] = grp.lo[3];
                ud[3] = grp.lo[2];
            end
            default: begin
                ud = grp.up;
                ld = grp.lo;
            end
        endcase
    end

endmodule

// File: rtl/lcd_dual_serializer.sv
module lcd_dual_serializer
    import lcds_pkg::*;
#(
    parameter int BW     = BYTE_W,
    parameter int HALVES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             disp_on,
    input  logic [1:0]       out_mode,
    input  logic [PIT_W-1:0] pitch,
    input  logic             chr_load,
    input  logic             line_blank,
    input  logic [BW-1:0]    up_byte,
    input  logic [BW-1:0]    lo_byte,
    output logic [NIB_W-1:0] ud,
    output logic [NIB_W-1:0] ld,
    output logic             clp
);

    logic             accept, pop;
    logic [PIT_W-1:0] hp_eff;
    logic [LAN_W-1:0] lanes;
    logic [BW-1:0]    half_byte [HALVES];
    logic [NIB_W-1:0] half_grp  [HALVES];
    logic [HALVES-1:0] half_ne;
    grp_pair_t        grp;

    assign accept       = chr_load && !line_blank && disp_on;
    assign hp_eff       = pitch_clamp(pitch);
    assign lanes        = lanes_of(out_mode);
    assign half_byte[0] = up_byte;
    assign half_byte[1] = lo_byte;

    generate
        for (genvar h = 0; h < HALVES; h++) begin : g_half
            lcds_bitq #(.BW(BW)) u_q (
                .clk      (clk),
                .rst      (rst),
                .clr      (!disp_on),
                .load     (accept),
                .din      (half_byte[h]),
                .pitch    (hp_eff),
                .lanes    (lanes),
                .pop      (pop),
                .grp      (half_grp[h]),
                .nonempty (half_ne[h])
            );
        end
    endgenerate

    lcds_pacer u_pacer (
        .clk       (clk),
        .rst       (rst),
        .en        (disp_on),
        .kick      (accept),
        .have_bits (half_ne[0]),
        .lanes     (lanes),
        .pop       (pop),
        .clp       (clp)
    );

    assign grp.up = half_grp[0];
    assign grp.lo = half_grp[1];

    lcds_pinmap u_map (
        .mode (out_mode),
        .grp  (grp),
        .ud   (ud),
        .ld   (ld)
    );

endmodule

// File: rtl/lcds_checker.sv
module lcds_checker
    import lcds_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             disp_on,
    input logic [1:0]       out_mode,
    input logic [NIB_W-1:0] ud,
    input logic [NIB_W-1:0] ld,
    input logic             clp
);

    logic [3:0] hi_run;

    always_ff @(posedge clk) begin
        if (rst)      hi_run <= '0;
        else if (clp) hi_run <= hi_run + 1'b1;
        else          hi_run <= '0;
    end

    AST_CLP_HIGH_WIDTH: assert property (@(posedge clk) disable iff (rst)
        ($fell(clp) && $past(disp_on)) |-> (hi_run == 4'(lanes_of(out_mode)))); // R6

    AST_DATA_STABLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !$stable({ud, ld}) |-> !clp); // R7

    AST_OFF_OUTPUTS_LOW: assert property (@(posedge clk) disable iff (rst)
        !disp_on |=> (ud == '0 && ld == '0 && !clp)); // R9

    AST_LOWER_BUS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (out_mode[1] == 1'b0) |-> (ld == '0)); // R10

endmodule

bind lcd_dual_serializer lcds_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .disp_on  (disp_on),
    .out_mode (out_mode),
    .ud       (ud),
    .ld       (ld),
    .clp      (clp)
);

// File: tb/tb_lcd_dual_serializer.sv
module tb_lcd_dual_serializer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       disp_on = 1'b0;
    logic [1:0] out_mode = 2'b00;
    logic [3:0] pitch = 4'd8;
    logic       chr_load = 1'b0;
    logic       line_blank = 1'b1;
    logic [7:0] up_byte = '0;
    logic [7:0] lo_byte = '0;
    logic [3:0] ud, ld;
    logic       clp;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    lcd_dual_serializer dut (
        .clk(clk), .rst(rst), .disp_on(disp_on), .out_mode(out_mode),
        .pitch(pitch), .chr_load(chr_load), .line_blank(line_blank),
        .up_byte(up_byte), .lo_byte(lo_byte), .ud(ud), .ld(ld), .clp(clp)
    );

    always #4 clk = ~clk;

    // capture on every shift-clock rise, sampled at the falling block-clock edge
    logic [1:0] cur_mode = 2'b00;
    int         ncap = 0;
    int         cyc = 0;
    int         stable_err = 0;
    logic       prev_clp = 1'b0;
    logic [3:0] cap_u [64];
    logic [3:0] cap_l [64];
    logic [3:0] cap_ld [64];
    int         cap_t [64];
    logic [7:0] hold_pins;

    function automatic logic [3:0] dec_up(input logic [1:0] m, input logic [3:0] u);
        case (m)
            2'b00:   dec_up = {u[0], 3'b000};
            2'b01:   dec_up = {u[0], u[1], 2'b00};
            default: dec_up = u;
        endcase
    endfunction

    function automatic logic [3:0] dec_lo(input logic [1:0] m, input logic [3:0] u, input logic [3:0] l);
        case (m)
            2'b00:   dec_lo = {u[1], 3'b000};
            2'b01:   dec_lo = {u[2], u[3], 2'b00};
            default: dec_lo = l;
        endcase
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (clp && !prev_clp && ncap < 64) begin
            cap_u[ncap]  = dec_up(cur_mode, ud);
            cap_l[ncap]  = dec_lo(cur_mode, ud, ld);
            cap_ld[ncap] = ld;
            cap_t[ncap]  = cyc;
            hold_pins    = {ud, ld};
            ncap = ncap + 1;
        end else if (clp && prev_clp && hold_pins != {ud, ld}) begin
            stable_err = stable_err + 1;
        end
        prev_clp = clp;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int got, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic run_line(input logic [1:0] m, input logic [3:0] hp, input int nch);
        int         heff, w, total, ngrp;
        logic       ub [128];
        logic       lb [128];
        logic [7:0] a, b;
        string      mreq, creq;
        heff = (hp < 4) ? 4 : ((hp > 8) ? 8 : int'(hp));
        w    = (m == 2'b00) ? 1 : ((m == 2'b01) ? 2 : 4);
        mreq = (m == 2'b00) ? "R2" : ((m == 2'b01) ? "R3" : "R4");
        creq = (hp < 4 || hp > 8) ? "R11" : "R5";
        for (int k = 0; k < 128; k++) begin
            ub[k] = 1'b0;
            lb[k] = 1'b0;
        end
        out_mode   = m;
        pitch      = hp;
        cur_mode   = m;
        tick(2);
        ncap       = 0;
        stable_err = 0;
        line_blank = 1'b0;
        for (int c = 0; c < nch; c++) begin
            a = 8'($urandom);
            b = 8'($urandom);
            for (int j = 0; j < heff; j++) begin
                ub[c*heff + j] = a[7-j];
                lb[c*heff + j] = b[7-j];
            end
            up_byte  = a;
            lo_byte  = b;
            chr_load = 1'b1;
            tick(1);
            chr_load = 1'b0;
            tick(2*heff - 1);
        end
        line_blank = 1'b1;
        tick(80);
        total = nch * heff;
        ngrp  = (total + w - 1) / w;
        check(ncap == ngrp, creq, "shift clock count", ncap, ngrp);
        for (int g = 0; g < ncap && g < ngrp; g++) begin
            logic [3:0] eu, el;
            eu = '0;
            el = '0;
            for (int i = 0; i < w; i++) begin
                eu[3-i] = (g*w + i < total) ? ub[g*w + i] : 1'b0;
                el[3-i] = (g*w + i < total) ? lb[g*w + i] : 1'b0;
            end
            check(cap_u[g] == eu, mreq, $sformatf("upper group %0d", g), cap_u[g], eu);
            check(cap_l[g] == el, mreq, $sformatf("lower group %0d (R5 packing)", g), cap_l[g], el);
            if (m[1] == 1'b0)
                check(cap_ld[g] == 4'h0, "R10", "ld outside nibble mode", cap_ld[g], 0);
            if (g > 0)
                check(cap_t[g] - cap_t[g-1] == 2*w, "R6", "shift clock period",
                      cap_t[g] - cap_t[g-1], 2*w);
        end
        check(stable_err == 0, "R7", "data moved while clp high", stable_err, 0);
        // R8: loads during blanking are ignored and nothing more is shifted
        begin
            int n0;
            n0 = ncap;
            up_byte  = 8'hFF;
            lo_byte  = 8'hFF;
            chr_load = 1'b1;
            tick(1);
            chr_load = 1'b0;
            tick(30);
            @(negedge clk);
            check(ncap == n0, "R8", "shift clocks during blank", ncap - n0, 0);
            check(ud == 4'h0 && ld == 4'h0 && clp == 1'b0, "R8", "pins during blank",
                  {ud, ld, 3'b0, clp}, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        tick(4);
        @(negedge clk);
        check(ud == 4'h0 && ld == 4'h0 && clp == 1'b0, "R1", "outputs in reset",
              {ud, ld, 3'b0, clp}, 0);
        rst = 1'b0;
        tick(1);
        @(negedge clk);
        check(ud == 4'h0 && ld == 4'h0 && clp == 1'b0, "R1", "outputs after reset",
              {ud, ld, 3'b0, clp}, 0);

        // R9: display switched off in the middle of a nibble-mode line
        disp_on    = 1'b1;
        out_mode   = 2'b10;
        cur_mode   = 2'b10;
        pitch      = 4'd8;
        tick(2);
        line_blank = 1'b0;
        for (int c = 0; c < 3; c++) begin
            up_byte  = 8'hA5;
            lo_byte  = 8'h3C;
            chr_load = 1'b1;
            tick(1);
            chr_load = 1'b0;
            tick(15);
        end
        disp_on  = 1'b0;
        chr_load = 1'b1;
        tick(1);
        chr_load = 1'b0;
        begin
            int bad;
            bad = 0;
            for (int k = 0; k < 12; k++) begin
                @(negedge clk);
                if (ud != 4'h0 || ld != 4'h0 || clp) bad++;
            end
            check(bad == 0, "R9", "cycles with live outputs while off", bad, 0);
        end
        line_blank = 1'b1;
        disp_on    = 1'b1;
        tick(20);
        @(negedge clk);
        check(ud == 4'h0 && ld == 4'h0 && clp == 1'b0, "R9", "queue discarded on re-enable",
              {ud, ld, 3'b0, clp}, 0);

        // sweep all modes against all pitches, including clamped values (R11)
        for (int mi = 0; mi < 4; mi++) begin
            for (int hp = 3; hp <= 9; hp++) begin
                logic [3:0] hpv;
                hpv = (hp == 9) ? 4'd12 : ((hp == 3) ? 4'd2 : 4'(hp));
                run_line(2'(mi), hpv, 7);
            end
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule